// File: doc/BRIEF.md
# Table Base Register Bank

This block holds the base registers that describe the in-memory tables of an interrupt translation unit. It has eight 64-bit slots at consecutive 8-byte offsets. Slot 0 describes the device table and slot 1 describes the collection table. The remaining six slots have no storage: they read as zero and drop any write.

Software reaches the bank through a single access port. The port takes 32-bit or 64-bit accesses, and reads are combinational on the address. Every write is first merged into the stored value and then rewritten before it is stored. Read-only and fixed fields are forced, unsupported address bits are cleared, and reserved memory-attribute encodings are replaced with legal ones. A value read back therefore need not match the value written.

A global enable input freezes the whole bank. While it is high, writes are ignored and reads still work. Walking the tables and allocating their memory are left to other blocks.

Top module: `tbr_bank`

## Requirements
- R1: The slot is `acc_addr[5:3]` (address divided by 8, modulo 8), so upper address bits alias. Slot 0 is the device table and slot 1 is the collection table. Slots 2 to 7 read zero and ignore writes.
- R2: After reset, slot 0 reads 64'h1907_0000_0000_0600 and slot 1 reads 64'h1C07_0000_0000_0600. These values encode inner cacheability 3 (read-allocate write-back), outer 0 (same as inner), shareability 1 (inner), entry size 7, page size 2 (64 KB) and type 1 or 4.
- R3: While `bank_en` is high, a write changes no slot.
- R4: A 64-bit access (`acc_wide`=1) reads or writes all 64 bits. A 32-bit access with `acc_addr[2]`=0 uses bits 31:0, and with `acc_addr[2]`=1 it uses bits 63:32. The data is carried in `acc_wdata[31:0]`, and narrow reads return the selected half zero-extended.
- R5: After any write, bits 52:48 (entry size) read 7. Bits 58:56 (type) read 1 in slot 0 and 4 in slot 1.
- R6: Bit 62 (indirect) is cleared on slot 1 only. On slot 0 it keeps the written value.
- R7: Bits 15:12 are cleared and bits 9:8 (page size) read 2 after any write.
- R8: Shareability bits 11:10: a written 2 or 3 is stored as 1, and 0 or 1 are kept.
- R9: Inner cacheability bits 61:59: a written 0 is stored as 1, and other codes are kept. Outer cacheability bits 55:53: codes 2 to 7 are stored as 0, and 0 or 1 are kept.
- R10: Bits 7:0, 47:16 and 63 are stored exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_en | input | 1 | Global enable; while high, the bank ignores writes |
| acc_wr | input | 1 | Write strobe for the current access |
| acc_addr | input | 8 | Byte address of the access |
| acc_wide | input | 1 | 1 selects a 64-bit access, 0 selects a 32-bit access |
| acc_wdata | input | 64 | Write data (narrow writes use bits 31:0) |
| rd_data | output | 64 | Combinational read data for `acc_addr` |

## Verification
A vector table drives three kinds of write: full-width writes of all ones, all zeros and mixed patterns, and narrow writes to each half. Writes to slots without storage and writes while the bank is enabled are mixed into the same table. After every write both live slots are read back and compared with an independently written sanitising model. Read-back separates merging errors (the wrong half updated) from forcing errors (a field left as written). Directed cases then hit each reserved attribute encoding, the indirect bit on both slots, and an aliased address above 64. Each of these separates one mask or replacement rule from its neighbours.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  localparam int unsigned REG_W = 64;

  // field positions used by the sanitiser
  localparam int unsigned F_PG_LO  = 8;
  localparam int unsigned F_PG_HI  = 9;
  localparam int unsigned F_SH_LO  = 10;
  localparam int unsigned F_SH_HI  = 11;
  localparam int unsigned F_PAH_LO = 12;
  localparam int unsigned F_PAH_HI = 15;
  localparam int unsigned F_ES_LO  = 48;
  localparam int unsigned F_ES_HI  = 52;
  localparam int unsigned F_OC_LO  = 53;
  localparam int unsigned F_OC_HI  = 55;
  localparam int unsigned F_TY_LO  = 56;
  localparam int unsigned F_TY_HI  = 58;
  localparam int unsigned F_IC_LO  = 59;
  localparam int unsigned F_IC_HI  = 61;
  localparam int unsigned F_IND    = 62;

  localparam logic [1:0] PG_64K      = 2'd2;
  localparam logic [4:0] ES_8BYTE    = 5'd7;
  localparam logic [1:0] SH_INNER    = 2'd1;
  localparam logic [2:0] IC_NONCACHE = 3'd1;
  localparam logic [2:0] IC_RAWB     = 3'd3;
  localparam logic [2:0] OC_SAME     = 3'd0;

  typedef enum logic [2:0] {
    TT_NONE   = 3'd0,
    TT_DEVICE = 3'd1,
    TT_COLL   = 3'd4
  } tbl_type_e;

  function automatic logic [REG_W-1:0] merge_word(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] wd,
                                                  input logic wide,
                                                  input logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[31:0], old_v[31:0]};
    else         return {old_v[63:32], wd[31:0]};
  endfunction

  function automatic logic [1:0] fix_share(input logic [1:0] s);
    return (s > SH_INNER) ? SH_INNER : s;
  endfunction

  function automatic logic [2:0] fix_inner(input logic [2:0] c);
    return (c == 3'd0) ? IC_NONCACHE : c;
  endfunction

  function automatic logic [2:0] fix_outer(input logic [2:0] c);
    return (c > 3'd1) ? OC_SAME : c;
  endfunction

  function automatic logic [REG_W-1:0] sanitize_entry(input logic [REG_W-1:0] v,
                                                      input tbl_type_e typ,
                                                      input logic clr_ind);
    logic [REG_W-1:0] r;
    r = v;
    r[F_ES_HI:F_ES_LO]   = ES_8BYTE;
    r[F_TY_HI:F_TY_LO]   = typ;
    r[F_PAH_HI:F_PAH_LO] = 4'd0;
    r[F_PG_HI:F_PG_LO]   = PG_64K;
    r[F_SH_HI:F_SH_LO]   = fix_share(v[F_SH_HI:F_SH_LO]);
    r[F_IC_HI:F_IC_LO]   = fix_inner(v[F_IC_HI:F_IC_LO]);
    r[F_OC_HI:F_OC_LO]   = fix_outer(v[F_OC_HI:F_OC_LO]);
    if (clr_ind) r[F_IND] = 1'b0;
    return r;
  endfunction

  function automatic logic [REG_W-1:0] reset_value(input tbl_type_e typ);
    logic [REG_W-1:0] r;
    r = '0;
    r[F_IC_HI:F_IC_LO] = IC_RAWB;
    r[F_OC_HI:F_OC_LO] = OC_SAME;
    r[F_SH_HI:F_SH_LO] = SH_INNER;
    r[F_ES_HI:F_ES_LO] = ES_8BYTE;
    r[F_PG_HI:F_PG_LO] = PG_64K;
    r[F_TY_HI:F_TY_LO] = typ;
    return r;
  endfunction

endpackage

// File: rtl/tbr_decode.sv
module tbr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              acc_wr,
  input  logic              bank_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wide,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              hi_sel,
  output logic [NUM_SLOTS-1:0] slot_fire
);
  localparam int unsigned IDX_LO = 3;
  localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

  assign slot_idx = acc_addr[IDX_HI:IDX_LO];
  assign hi_sel   = !acc_wide && acc_addr[2];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_fire
    assign slot_fire[i] = acc_wr && !bank_en && (slot_idx == IDX_W'(i));
  end

  logic unused_addr_lo;
  assign unused_addr_lo = ^acc_addr[1:0];

  if (ADDR_W > IDX_HI + 1) begin : g_alias
    logic unused_addr_hi;
    assign unused_addr_hi = ^acc_addr[ADDR_W-1:IDX_HI+1];
  end
endmodule

// File: rtl/tbr_entry.sv
module tbr_entry #(
  parameter tbr_pkg::tbl_type_e TYPE = tbr_pkg::TT_DEVICE,
  parameter bit CLR_IND = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic                      wide,
  input  logic                      hi_sel,
  input  logic [tbr_pkg::REG_W-1:0] wdata,
  output logic [tbr_pkg::REG_W-1:0] q
);
  import tbr_pkg::*;

  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] cleaned;

  assign merged  = merge_word(q, wdata, wide, hi_sel);
  assign cleaned = sanitize_entry(merged, TYPE, CLR_IND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= reset_value(TYPE);
    else if (fire) q <= cleaned;
  end
endmodule

// File: rtl/tbr_rdmux.sv
module tbr_rdmux #(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [tbr_pkg::REG_W-1:0] slot_q [NUM_SLOTS],
  input  logic [IDX_W-1:0]          slot_idx,
  input  logic                      wide,
  input  logic                      hi_sel,
  output logic [tbr_pkg::REG_W-1:0] rd_data
);
  logic [tbr_pkg::REG_W-1:0] sel;

  always_comb begin
    sel = slot_q[slot_idx];
    if (wide)        rd_data = sel;
    else if (hi_sel) rd_data = {32'd0, sel[63:32]};
    else             rd_data = {32'd0, sel[31:0]};
  end
endmodule

// File: rtl/tbr_bank.sv
module tbr_bank #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wide,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       rd_data
);
  import tbr_pkg::*;

  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS);
  localparam int unsigned NUM_IMPL = 2;

  logic [IDX_W-1:0]     slot_idx;
  logic                 hi_sel;
  logic [NUM_SLOTS-1:0] slot_fire;
  logic [REG_W-1:0]     slot_q [NUM_SLOTS];

  tbr_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
    .acc_wr   (acc_wr),
    .bank_en  (bank_en),
    .acc_addr (acc_addr),
    .acc_wide (acc_wide),
    .slot_idx (slot_idx),
    .hi_sel   (hi_sel),
    .slot_fire(slot_fire)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_dev
      tbr_entry #(.TYPE(TT_DEVICE), .CLR_IND(1'b0)) u_ent (
        .clk(clk), .rst_n(rst_n), .fire(slot_fire[i]), .wide(acc_wide),
        .hi_sel(hi_sel), .wdata(acc_wdata), .q(slot_q[i])
      );
    end else if (i < NUM_IMPL) begin : g_coll
      tbr_entry #(.TYPE(TT_COLL), .CLR_IND(1'b1)) u_ent (
        .clk(clk), .rst_n(rst_n), .fire(slot_fire[i]), .wide(acc_wide),
        .hi_sel(hi_sel), .wdata(acc_wdata), .q(slot_q[i])
      );
    end else begin : g_none
      assign slot_q[i] = '0;
    end
  end

  tbr_rdmux #(.NUM_SLOTS(NUM_SLOTS)) u_rd (
    .slot_q  (slot_q),
    .slot_idx(slot_idx),
    .wide    (acc_wide),
    .hi_sel  (hi_sel),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/tbr_bank_chk.sv
module tbr_bank_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bank_en,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic                 acc_wide,
  input logic [63:0]          acc_wdata,
  input logic [63:0]          rd_data,
  input logic [NUM_SLOTS-1:0] slot_fire,
  input logic [63:0]          dev_q,
  input logic [63:0]          coll_q
);
  AST_FIRE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(slot_fire)); // R1
  AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[5:3] > 3'd1) |-> (rd_data == 64'd0)); // R1
  AST_EN_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n) bank_en |-> (slot_fire == '0)); // R3
  AST_EN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en |=> ($stable(dev_q) && $stable(coll_q))); // R3
  AST_NARROW_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire[0] && !acc_wide && !acc_addr[2]) |=> (dev_q[63:32] == $past(dev_q[63:32]))); // R4
  AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q[52:48] == 5'd7) && (coll_q[52:48] == 5'd7) && (dev_q[58:56] == 3'd1) && (coll_q[58:56] == 3'd4)); // R5
  AST_COLL_FLAT: assert property (@(posedge clk) disable iff (!rst_n) !coll_q[62]); // R6
  AST_ADDR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q[15:12] == 4'd0) && (coll_q[15:12] == 4'd0) && (dev_q[9:8] == 2'd2) && (coll_q[9:8] == 2'd2)); // R7
  AST_SHARE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q[11:10] < 2'd2) && (coll_q[11:10] < 2'd2)); // R8
  AST_CACHE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q[61:59] != 3'd0) && (coll_q[61:59] != 3'd0) && (dev_q[55:53] < 3'd2) && (coll_q[55:53] < 3'd2)); // R9
  AST_WIDE_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire[0] && acc_wide) |=> (dev_q[47:16] == $past(acc_wdata[47:16]))); // R10
endmodule

bind tbr_bank tbr_bank_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bank_en  (bank_en),
  .acc_addr (acc_addr),
  .acc_wide (acc_wide),
  .acc_wdata(acc_wdata),
  .rd_data  (rd_data),
  .slot_fire(slot_fire),
  .dev_q    (slot_q[0]),
  .coll_q   (slot_q[1])
);

// File: tb/tbr_bank_bench.sv
`timescale 1ns/1ps
module tbr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_addr = 8'd0;
  logic        acc_wide = 1'b1;
  logic [63:0] acc_wdata = 64'd0;
  logic [63:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] shadow [2];

  always #2 clk = ~clk;

  tbr_bank u_tbr_bank (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wide(acc_wide), .acc_wdata(acc_wdata), .rd_data(rd_data)
  );

  // {en, wide, addr[7:0], data[63:0]}
  localparam int NV = 12;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b1, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b1, 8'h00, 64'h0000_0000_0000_0000},
    {1'b0, 1'b0, 8'h00, 64'h0000_0000_1234_F678},
    {1'b0, 1'b0, 8'h04, 64'h0000_0000_8000_0000},
    {1'b0, 1'b1, 8'h08, 64'h0000_1234_5678_0800},
    {1'b0, 1'b1, 8'h18, 64'hDEAD_BEEF_DEAD_BEEF},
    {1'b0, 1'b1, 8'h38, 64'h0123_4567_89AB_CDEF},
    {1'b1, 1'b1, 8'h00, 64'h5555_5555_5555_5555},
    {1'b1, 1'b0, 8'h0C, 64'h0000_0000_FFFF_FFFF},
    {1'b0, 1'b1, 8'h08, 64'h5A5A_A5A5_3C3C_C3C3},
    {1'b0, 1'b0, 8'h0C, 64'h0000_0000_7FFF_0000}
  };

  function automatic logic [63:0] model_fix(input logic [63:0] v, input bit coll);
    logic [63:0] r;
    r = v & ~64'h071F_0000_0000_F300;
    r = r | 64'h0007_0000_0000_0200;
    r = r | (coll ? 64'h0400_0000_0000_0000 : 64'h0100_0000_0000_0000);
    if (coll) r = r & ~64'h4000_0000_0000_0000;
    if (r[11:10] >= 2'd2) r[11:10] = 2'd1;
    if (r[61:59] == 3'd0) r[61:59] = 3'd1;
    if (r[55:53] >= 3'd2) r[55:53] = 3'd0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic en, input logic wide, input logic [7:0] a, input logic [63:0] d);
    int idx;
    logic [63:0] m;
    @(negedge clk);
    bank_en = en; acc_wr = 1'b1; acc_wide = wide; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0; bank_en = 1'b0;
    idx = int'(a[5:3]);
    if (!en && idx < 2) begin
      m = shadow[idx];
      if (wide)      m = d;
      else if (a[2]) m[63:32] = d[31:0];
      else           m[31:0] = d[31:0];
      shadow[idx] = model_fix(m, idx == 1);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic wide, output logic [63:0] d);
    @(negedge clk);
    acc_addr = a; acc_wide = wide;
    #1;
    d = rd_data;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    shadow[0] = 64'h1907_0000_0000_0600;
    shadow[1] = 64'h1C07_0000_0000_0600;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    rd(8'h00, 1'b1, v); check("R2 device reset", v, 64'h1907_0000_0000_0600);
    rd(8'h08, 1'b1, v); check("R2 collection reset", v, 64'h1C07_0000_0000_0600);
    rd(8'h10, 1'b1, v); check("R1 empty slot reset", v, 64'd0);

    // vector table: writes, then both live slots compared with the model
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][73], VEC[i][72], VEC[i][71:64], VEC[i][63:0]);
      rd(8'h00, 1'b1, v); check($sformatf("R3 R4 R10 vec%0d device", i), v, shadow[0]);
      rd(8'h08, 1'b1, v); check($sformatf("R3 R4 R10 vec%0d collection", i), v, shadow[1]);
      rd(VEC[i][71:64], 1'b1, v);
      check($sformatf("R1 vec%0d written slot", i), v,
            (VEC[i][69:67] < 3'd2) ? shadow[VEC[i][67]] : 64'd0);
    end

    // R1 aliasing above 64
    wr(1'b0, 1'b1, 8'h40, 64'h8000_ABCD_0000_0011);
    rd(8'h00, 1'b1, v); check("R1 alias 0x40 to slot 0", v, shadow[0]);
    rd(8'h48, 1'b1, v); check("R1 alias 0x48 to slot 1", v, shadow[1]);
    rd(8'h38, 1'b1, v); check("R1 slot 7 reads zero", v, 64'd0);

    // R4 narrow reads
    rd(8'h04, 1'b0, v); check("R4 narrow read high half", v, {32'd0, shadow[0][63:32]});
    rd(8'h00, 1'b0, v); check("R4 narrow read low half", v, {32'd0, shadow[0][31:0]});

    // R5 forced fields
    wr(1'b0, 1'b1, 8'h00, 64'h0700_0000_0000_0000);
    rd(8'h00, 1'b1, v); check("R5 device type", {61'd0, v[58:56]}, 64'd1);
    check("R5 device entry size", {59'd0, v[52:48]}, 64'd7);
    wr(1'b0, 1'b1, 8'h08, 64'h0000_0000_0000_0000);
    rd(8'h08, 1'b1, v); check("R5 collection type", {61'd0, v[58:56]}, 64'd4);

    // R6 indirect bit
    wr(1'b0, 1'b1, 8'h00, 64'h4000_0000_0000_0000);
    rd(8'h00, 1'b1, v); check("R6 device keeps indirect", {63'd0, v[62]}, 64'd1);
    wr(1'b0, 1'b1, 8'h08, 64'h4000_0000_0000_0000);
    rd(8'h08, 1'b1, v); check("R6 collection clears indirect", {63'd0, v[62]}, 64'd0);

    // R7 address and page bits
    wr(1'b0, 1'b0, 8'h00, 64'h0000_0000_0000_F000);
    rd(8'h00, 1'b0, v); check("R7 bits 15:12 and page", {48'd0, v[15:8]}, 64'h02);

    // R8 shareability
    wr(1'b0, 1'b1, 8'h00, 64'h0000_0000_0000_0C00);
    rd(8'h00, 1'b1, v); check("R8 share 3 to 1", {62'd0, v[11:10]}, 64'd1);
    wr(1'b0, 1'b1, 8'h00, 64'h0000_0000_0000_0000);
    rd(8'h00, 1'b1, v); check("R8 share 0 kept", {62'd0, v[11:10]}, 64'd0);

    // R9 cacheability (value 0 just written)
    check("R9 inner 0 to 1", {61'd0, v[61:59]}, 64'd1);
    wr(1'b0, 1'b1, 8'h00, 64'h28C0_0000_0000_0000);
    rd(8'h00, 1'b1, v); check("R9 inner 5 kept", {61'd0, v[61:59]}, 64'd5);
    check("R9 outer 6 to 0", {61'd0, v[55:53]}, 64'd0);
    wr(1'b0, 1'b1, 8'h00, 64'h0020_0000_0000_0000);
    rd(8'h00, 1'b1, v); check("R9 outer 1 kept", {61'd0, v[55:53]}, 64'd1);

    // R10 pass-through
    wr(1'b0, 1'b1, 8'h08, 64'h8000_9876_5432_00A5);
    rd(8'h08, 1'b1, v);
    check("R10 pass-through fields", {v[63], 15'd0, v[47:16], 8'd0, v[7:0]},
          {1'b1, 15'd0, 32'h9876_5432, 8'd0, 8'hA5});

    // R3 frozen bank
    wr(1'b1, 1'b1, 8'h08, 64'h0000_0000_0000_0000);
    rd(8'h08, 1'b1, v); check("R3 enabled write ignored", v, shadow[1]);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule